// File: doc/BRIEF.md
# Extended Cartridge Bank Register File

This block holds the bank-select and bank-data registers of an 8-bit console cartridge mapper. It has twelve 8-bit bank registers, a selector with two inversion flags, and a two-bit nametable arrangement register. All of them are loaded by CPU writes. Each cycle it turns the window address of the current CPU access (A15..A13) into an 8 KiB program bank number. It also turns the window address of the current pattern fetch (A12..A10) into a 1 KiB character bank number. Both results are combinational, so the surrounding mapper can add outer-bank bits before driving the ROM address lines.

The block has two modes, picked by the `ext_mode` input. In normal mode the registers behave like the classic six-register scheme: two 2 KiB character windows, four 1 KiB character windows, and two switchable 8 KiB program windows of 6 significant bits. The other two program windows are fixed to the last two 8 KiB banks of a 512 KiB space. Extended mode brings four extra registers into use. The two fixed program windows become selectable, each 2 KiB character window splits into two 1 KiB windows, and all eight program bank bits reach the output.

The block also drives the nametable RAM address line from the arrangement register and the PPU address bits.

Top module: `cart_bank_regs`

## Requirements
- R1: After reset the bank registers 0 to 11 hold $00,$02,$04,$05,$06,$07,$00,$01,$FE,$FF,$FF,$FF. Both inversion flags are 0 and the arrangement register is 0.
- R2: A write with address bits 15..13 = 100 and bit 0 = 0 loads the selector. Data bits 3..0 are the target index, bit 6 is the program inversion flag (`prg_inv`) and bit 7 is the character inversion flag (`chr_inv`). All of them are visible from the next cycle on.
- R3: A write with address bits 15..13 = 100 and bit 0 = 1 loads the data byte into the register named by the target index. Target indices 12 to 15 change no register.
- R4: In normal mode with `chr_inv` = 0, character windows 0..3 (`ppu_win` = A12..A10) read register 0 for windows 0 and 1 and register 1 for windows 2 and 3. Bit 0 of the register is replaced by A10. Windows 4..7 read registers 2, 3, 4 and 5.
- R5: With `chr_inv` = 1 the character mapping of either mode uses the window number with bit 2 (A12) inverted.
- R6: In extended mode with `chr_inv` = 0, character windows 0..7 read registers 0, 10, 1, 11, 2, 3, 4, 5 with all 8 bits.
- R7: In normal mode, program windows 4 and 5 (A15..A13 = 100 and 101) return registers 6 and 7 masked to 6 bits, window 6 returns $3E and window 7 returns $3F. With `prg_inv` = 1, windows 4 and 6 exchange their sources.
- R8: In extended mode, program windows 4..7 return registers 6, 7, 8 and 9 with all 8 bits. With `prg_inv` = 1, registers 6 and 8 exchange windows.
- R9: A write with address bits 15..13 = 101 and bit 0 = 0 loads data bits 1..0 into the arrangement register. `ciram_a10` is then PPU A10 for 0, PPU A11 for 1, 0 for 2 and 1 for 3.
- R10: Writes with `wr_en` low, with address bits 15..13 outside 100 and 101, or to 101 with bit 0 = 1, change no register.
- R11: `prg_bank` is 0 while A15 of the CPU window (`cpu_win[2]`) is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| ext_mode | input | 1 | 1 selects extended mode |
| cpu_win | input | 3 | CPU access address bits A15..A13 |
| ppu_win | input | 3 | PPU access address bits A12..A10 |
| prg_bank | output | 8 | 8 KiB program bank number |
| chr_bank | output | 8 | 1 KiB character bank number |
| prg_inv | output | 1 | Program inversion flag |
| chr_inv | output | 1 | Character inversion flag |
| mirror_mode | output | 2 | Nametable arrangement register |
| ciram_a10 | output | 1 | Nametable RAM address line A10 |

## Verification
The assertions assume that each CPU write is a single-cycle `wr_en` pulse with a stable address and data. They also assume that `ext_mode` and the window inputs are settled before the clock edge, because the bank outputs are combinational in them. The bench drives every input just after a falling edge and samples it one time step later, and it raises `wr_en` for exactly one rising edge per write. The fixed-bank and mask properties depend on `ext_mode` being held for the whole cycle. The bench changes it only between lookups, never during a write.

// File: rtl/cbr_pkg.sv
// Package: shared constants and reset values for the cartridge bank register file.
// Assumes an 8-bit CPU data bus and a fixed set of twelve bank registers.
package cbr_pkg;
    localparam int NUM_REGS = 12;
    localparam int SEL_W    = 4;

    // Power-on content of bank register idx.
    function automatic logic [7:0] bank_reset_val(input int idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'h02;
            2:       return 8'h04;
            3:       return 8'h05;
            4:       return 8'h06;
            5:       return 8'h07;
            6:       return 8'h00;
            7:       return 8'h01;
            8:       return 8'hFE;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/cbr_ctrl.sv
// Module: write decoder, selector register, inversion flags and arrangement register.
// Assumes wr_en is a one-cycle strobe per CPU write; reset is synchronous, active low.
module cbr_ctrl
    import cbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [15:0]      wr_addr,
    input  logic [7:0]       wr_data,
    output logic [SEL_W-1:0] sel_idx,
    output logic             prg_inv,
    output logic             chr_inv,
    output logic [1:0]       mirror_mode,
    output logic             data_we
);
    logic sel_we;
    logic mir_we;

    // Decode the three write targets from the window bits and A0.
    always_comb begin
        sel_we  = wr_en && (wr_addr[15:13] == 3'b100) && !wr_addr[0];
        data_we = wr_en && (wr_addr[15:13] == 3'b100) &&  wr_addr[0];
        mir_we  = wr_en && (wr_addr[15:13] == 3'b101) && !wr_addr[0];
    end

    // Selector and inversion flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx <= '0;
            prg_inv <= 1'b0;
            chr_inv <= 1'b0;
        end else if (sel_we) begin
            sel_idx <= wr_data[SEL_W-1:0];
            prg_inv <= wr_data[6];
            chr_inv <= wr_data[7];
        end
    end

    // Nametable arrangement register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mirror_mode <= 2'd0;
        else if (mir_we)
            mirror_mode <= wr_data[1:0];
    end
endmodule

// File: rtl/cbr_regfile.sv
// Module: twelve bank registers, each loaded when the selector names it.
// Assumes selector values at or above NUM_REGS match no register and are dropped.
module cbr_regfile
    import cbr_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            data_we,
    input  logic [SEL_W-1:0]                sel_idx,
    input  logic [7:0]                      wr_data,
    output logic [NUM_REGS-1:0][BANK_W-1:0] bank_q
);
    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
            localparam logic [BANK_W-1:0] RST = BANK_W'(bank_reset_val(gi));
            // One bank register with its own power-on value.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bank_q[gi] <= RST;
                else if (data_we && (sel_idx == SEL_W'(gi)))
                    bank_q[gi] <= BANK_W'(wr_data);
            end
        end
    endgenerate
endmodule

// File: rtl/cbr_prg_map.sv
// Module: picks the 8 KiB program bank for the CPU window A15..A13.
// Assumes windows with A15 = 0 are not ROM and returns 0 for them.
module cbr_prg_map
    import cbr_pkg::*;
#(
    parameter int BANK_W     = 8,
    parameter int NORM_PRG_W = 6
) (
    input  logic                            ext_mode,
    input  logic                            prg_inv,
    input  logic [2:0]                      cpu_win,
    input  logic [NUM_REGS-1:0][BANK_W-1:0] bank_q,
    output logic [BANK_W-1:0]               prg_bank
);
    localparam logic [BANK_W-1:0] NORM_MASK = BANK_W'((1 << NORM_PRG_W) - 1);
    localparam logic [BANK_W-1:0] FIX_LAST  = NORM_MASK;
    localparam logic [BANK_W-1:0] FIX_PREV  = NORM_MASK - BANK_W'(1);

    logic [1:0] slot;

    // Swap windows 0 and 2 of the upper half when inverted.
    always_comb begin
        slot = cpu_win[1:0];
        if (prg_inv && !slot[0])
            slot[1] = ~slot[1];
    end

    // Select the source for the resulting slot.
    always_comb begin
        prg_bank = '0;
        if (cpu_win[2]) begin
            if (ext_mode) begin
                case (slot)
                    2'd0:    prg_bank = bank_q[6];
                    2'd1:    prg_bank = bank_q[7];
                    2'd2:    prg_bank = bank_q[8];
                    default: prg_bank = bank_q[9];
                endcase
            end else begin
                case (slot)
                    2'd0:    prg_bank = bank_q[6] & NORM_MASK;
                    2'd1:    prg_bank = bank_q[7] & NORM_MASK;
                    2'd2:    prg_bank = FIX_PREV;
                    default: prg_bank = FIX_LAST;
                endcase
            end
        end
    end
endmodule

// File: rtl/cbr_chr_map.sv
// Module: picks the 1 KiB character bank for the PPU window A12..A10.
// Assumes registers 0/1 cover 2 KiB in normal mode and are split by 10/11 in extended mode.
module cbr_chr_map
    import cbr_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic                            ext_mode,
    input  logic                            chr_inv,
    input  logic [2:0]                      ppu_win,
    input  logic [NUM_REGS-1:0][BANK_W-1:0] bank_q,
    output logic [BANK_W-1:0]               chr_bank
);
    logic [2:0]        win;
    logic [BANK_W-1:0] pair;

    // Inversion exchanges the two PPU halves.
    always_comb win = ppu_win ^ {chr_inv, 2'b00};

    // Source register for the resulting window.
    always_comb begin
        pair     = win[1] ? bank_q[1] : bank_q[0];
        chr_bank = '0;
        if (win[2]) begin
            case (win[1:0])
                2'd0:    chr_bank = bank_q[2];
                2'd1:    chr_bank = bank_q[3];
                2'd2:    chr_bank = bank_q[4];
                default: chr_bank = bank_q[5];
            endcase
        end else if (ext_mode) begin
            case (win[1:0])
                2'd0:    chr_bank = bank_q[0];
                2'd1:    chr_bank = bank_q[10];
                2'd2:    chr_bank = bank_q[1];
                default: chr_bank = bank_q[11];
            endcase
        end else begin
            chr_bank = {pair[BANK_W-1:1], win[0]};
        end
    end
endmodule

// File: rtl/cart_bank_regs.sv
// Module: top of the bank register file; ties decoder, registers and both mappers.
// Assumes one CPU write per wr_en cycle and settled window inputs during each cycle.
module cart_bank_regs
    import cbr_pkg::*;
#(
    parameter int BANK_W     = 8,
    parameter int NORM_PRG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              ext_mode,
    input  logic [2:0]        cpu_win,
    input  logic [2:0]        ppu_win,
    output logic [BANK_W-1:0] prg_bank,
    output logic [BANK_W-1:0] chr_bank,
    output logic              prg_inv,
    output logic              chr_inv,
    output logic [1:0]        mirror_mode,
    output logic              ciram_a10
);
    logic [SEL_W-1:0]                sel_idx;
    logic                            data_we;
    logic [NUM_REGS-1:0][BANK_W-1:0] bank_q;

    cbr_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .sel_idx     (sel_idx),
        .prg_inv     (prg_inv),
        .chr_inv     (chr_inv),
        .mirror_mode (mirror_mode),
        .data_we     (data_we)
    );

    cbr_regfile #(.BANK_W(BANK_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_we (data_we),
        .sel_idx (sel_idx),
        .wr_data (wr_data),
        .bank_q  (bank_q)
    );

    cbr_prg_map #(.BANK_W(BANK_W), .NORM_PRG_W(NORM_PRG_W)) u_prg (
        .ext_mode (ext_mode),
        .prg_inv  (prg_inv),
        .cpu_win  (cpu_win),
        .bank_q   (bank_q),
        .prg_bank (prg_bank)
    );

    cbr_chr_map #(.BANK_W(BANK_W)) u_chr (
        .ext_mode (ext_mode),
        .chr_inv  (chr_inv),
        .ppu_win  (ppu_win),
        .bank_q   (bank_q),
        .chr_bank (chr_bank)
    );

    // Nametable RAM line from the arrangement register.
    always_comb begin
        case (mirror_mode)
            2'd0:    ciram_a10 = ppu_win[0];
            2'd1:    ciram_a10 = ppu_win[1];
            2'd2:    ciram_a10 = 1'b0;
            default: ciram_a10 = 1'b1;
        endcase
    end
endmodule

// File: rtl/cart_bank_regs_chk.sv
// Module: property checker bound to cart_bank_regs; observes ports only.
// Assumes the same parameter defaults as the top module.
module cart_bank_regs_chk #(
    parameter int BANK_W     = 8,
    parameter int NORM_PRG_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [15:0]       wr_addr,
    input logic [7:0]        wr_data,
    input logic              ext_mode,
    input logic [2:0]        cpu_win,
    input logic [2:0]        ppu_win,
    input logic [BANK_W-1:0] prg_bank,
    input logic [BANK_W-1:0] chr_bank,
    input logic              prg_inv,
    input logic              chr_inv,
    input logic [1:0]        mirror_mode,
    input logic              ciram_a10
);
    localparam logic [BANK_W-1:0] LAST = BANK_W'((1 << NORM_PRG_W) - 1);

    logic sel_wr;
    logic mir_wr;
    always_comb begin
        sel_wr = wr_en && (wr_addr[15:13] == 3'b100) && !wr_addr[0];
        mir_wr = wr_en && (wr_addr[15:13] == 3'b101) && !wr_addr[0];
    end

    p_sel_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (prg_inv == $past(wr_data[6])) && (chr_inv == $past(wr_data[7])));

    p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> $stable(prg_inv) && $stable(chr_inv));

    p_mirror_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mir_wr |=> (mirror_mode == $past(wr_data[1:0])));

    p_mirror_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mir_wr |=> $stable(mirror_mode));

    p_fixed_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && cpu_win == 3'b111) |-> (prg_bank == LAST));

    p_norm_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode |-> (prg_bank <= LAST));

    p_low_half_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_win[2] |-> (prg_bank == '0));

    p_single_screen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mirror_mode[1] |-> (ciram_a10 == mirror_mode[0]));

    p_pair_low_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && (ppu_win[2] == chr_inv)) |-> (chr_bank[0] == ppu_win[0]));
endmodule

bind cart_bank_regs cart_bank_regs_chk #(.BANK_W(BANK_W), .NORM_PRG_W(NORM_PRG_W)) u_chk (.*);

// File: tb/sim_cart_bank_regs.sv
`timescale 1ns/1ps
module sim_cart_bank_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        ext_mode = 1'b0;
    logic [2:0]  cpu_win = '0;
    logic [2:0]  ppu_win = '0;
    logic [7:0]  prg_bank, chr_bank;
    logic        prg_inv, chr_inv, ciram_a10;
    logic [1:0]  mirror_mode;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cart_bank_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ext_mode(ext_mode), .cpu_win(cpu_win), .ppu_win(ppu_win),
        .prg_bank(prg_bank), .chr_bank(chr_bank), .prg_inv(prg_inv), .chr_inv(chr_inv),
        .mirror_mode(mirror_mode), .ciram_a10(ciram_a10)
    );

    // Fields: [14] ext, [13] prg_inv, [12] chr_inv, [11] chr lookup, [10:8] window, [7:0] expected.
    // Registers hold $A1 + 2*index when these are applied.
    localparam logic [14:0] VEC [48] = '{
        {4'b0001,3'd0,8'hA0}, {4'b0001,3'd1,8'hA1}, {4'b0001,3'd2,8'hA2}, {4'b0001,3'd3,8'hA3},
        {4'b0001,3'd4,8'hA5}, {4'b0001,3'd5,8'hA7}, {4'b0001,3'd6,8'hA9}, {4'b0001,3'd7,8'hAB},
        {4'b0011,3'd0,8'hA5}, {4'b0011,3'd1,8'hA7}, {4'b0011,3'd2,8'hA9}, {4'b0011,3'd3,8'hAB},
        {4'b0011,3'd4,8'hA0}, {4'b0011,3'd5,8'hA1}, {4'b0011,3'd6,8'hA2}, {4'b0011,3'd7,8'hA3},
        {4'b1001,3'd0,8'hA1}, {4'b1001,3'd1,8'hB5}, {4'b1001,3'd2,8'hA3}, {4'b1001,3'd3,8'hB7},
        {4'b1001,3'd4,8'hA5}, {4'b1001,3'd5,8'hA7}, {4'b1001,3'd6,8'hA9}, {4'b1001,3'd7,8'hAB},
        {4'b1011,3'd0,8'hA5}, {4'b1011,3'd1,8'hA7}, {4'b1011,3'd2,8'hA9}, {4'b1011,3'd3,8'hAB},
        {4'b1011,3'd4,8'hA1}, {4'b1011,3'd5,8'hB5}, {4'b1011,3'd6,8'hA3}, {4'b1011,3'd7,8'hB7},
        {4'b0000,3'd4,8'h2D}, {4'b0000,3'd5,8'h2F}, {4'b0000,3'd6,8'h3E}, {4'b0000,3'd7,8'h3F},
        {4'b0100,3'd4,8'h3E}, {4'b0100,3'd5,8'h2F}, {4'b0100,3'd6,8'h2D}, {4'b0100,3'd7,8'h3F},
        {4'b1000,3'd4,8'hAD}, {4'b1000,3'd5,8'hAF}, {4'b1000,3'd6,8'hB1}, {4'b1000,3'd7,8'hB3},
        {4'b1100,3'd4,8'hB1}, {4'b1100,3'd5,8'hAF}, {4'b1100,3'd6,8'hAD}, {4'b1100,3'd7,8'hB3}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic en, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look_chr(input string tag, input logic e, input logic [2:0] w, input logic [7:0] exp);
        ext_mode = e; ppu_win = w; #1;
        chk(tag, chr_bank, exp);
    endtask

    task automatic look_prg(input string tag, input logic e, input logic [2:0] w, input logic [7:0] exp);
        ext_mode = e; cpu_win = w; #1;
        chk(tag, prg_bank, exp);
    endtask

    task automatic look_nt(input string tag, input logic [2:0] w, input logic exp);
        ppu_win = w; #1;
        chk(tag, {7'd0, ciram_a10}, {7'd0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rst_chr [8] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07};
        logic [7:0] kept_chr [8] = '{8'hA1, 8'hB5, 8'hA3, 8'hB7, 8'hA5, 8'h42, 8'hA9, 8'hAB};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents seen through both mappers
        for (int i = 0; i < 8; i++) look_chr("R1 reset chr", 1'b0, 3'(i), rst_chr[i]);
        look_prg("R1 reset prg w4", 1'b0, 3'd4, 8'h00);
        look_prg("R1 reset prg w5", 1'b0, 3'd5, 8'h01);
        look_prg("R1 reset ext w6", 1'b1, 3'd6, 8'hFE);
        look_prg("R1 reset ext w7", 1'b1, 3'd7, 8'hFF);
        look_chr("R1 reset ext reg10", 1'b1, 3'd1, 8'hFF);
        look_chr("R1 reset ext reg11", 1'b1, 3'd3, 8'hFF);
        chk("R1 reset flags", {6'd0, prg_inv, chr_inv}, 8'h00);
        chk("R1 reset mirror", {6'd0, mirror_mode}, 8'h00);

        // Load all twelve registers with $A1 + 2*i
        for (int i = 0; i < 12; i++) begin
            cpu_wr(1'b1, 16'h8000, 8'(i));
            cpu_wr(1'b1, 16'h8001, 8'(8'hA1 + 2 * i));
        end

        // Table walk: R4 R5 R6 R7 R8
        for (int v = 0; v < 48; v++) begin
            logic [14:0] e = VEC[v];
            string tag;
            cpu_wr(1'b1, 16'h8000, {e[12], e[13], 6'h0F});
            if (e[11]) tag = e[14] ? (e[12] ? "R5 R6 ext chr inv" : "R6 ext chr")
                                   : (e[12] ? "R5 R4 chr inv" : "R4 chr");
            else       tag = e[14] ? "R8 ext prg" : "R7 norm prg";
            if (e[11]) look_chr(tag, e[14], e[10:8], e[7:0]);
            else       look_prg(tag, e[14], e[10:8], e[7:0]);
        end

        // R2: selector write sets both flags and index 3
        cpu_wr(1'b1, 16'h8000, 8'hC3);
        chk("R2 flags set", {6'd0, prg_inv, chr_inv}, 8'h03);
        // R3: data write lands in register 3 (window 1 when chr inverted, normal mode)
        cpu_wr(1'b1, 16'h8001, 8'h42);
        look_chr("R3 data to reg3", 1'b0, 3'd1, 8'h42);

        // R3: selector 12 drops the data byte; nothing else changes
        cpu_wr(1'b1, 16'h8000, 8'h0C);
        cpu_wr(1'b1, 16'h8001, 8'h55);
        for (int i = 0; i < 8; i++) look_chr("R3 sel12 ignored chr", 1'b1, 3'(i), kept_chr[i]);
        look_prg("R3 sel12 ignored w4", 1'b1, 3'd4, 8'hAD);
        look_prg("R3 sel12 ignored w5", 1'b1, 3'd5, 8'hAF);
        look_prg("R3 sel12 ignored w6", 1'b1, 3'd6, 8'hB1);
        look_prg("R3 sel12 ignored w7", 1'b1, 3'd7, 8'hB3);

        // R10: writes outside the decoded set
        cpu_wr(1'b0, 16'h8000, 8'hC5);
        chk("R10 strobe low flags", {6'd0, prg_inv, chr_inv}, 8'h00);
        cpu_wr(1'b1, 16'hC000, 8'hC5);
        chk("R10 wrong window flags", {6'd0, prg_inv, chr_inv}, 8'h00);
        cpu_wr(1'b1, 16'hA001, 8'h03);
        chk("R10 odd mirror addr", {6'd0, mirror_mode}, 8'h00);
        cpu_wr(1'b1, 16'h8000, 8'h00);
        cpu_wr(1'b1, 16'h2001, 8'h77);
        look_chr("R10 low window data", 1'b1, 3'd0, 8'hA1);
        cpu_wr(1'b0, 16'h8001, 8'h77);
        look_chr("R10 strobe low data", 1'b1, 3'd0, 8'hA1);

        // R9: arrangement encodings
        look_nt("R9 vertical A10=1", 3'b001, 1'b1);
        look_nt("R9 vertical A11=1", 3'b010, 1'b0);
        cpu_wr(1'b1, 16'hA000, 8'h01);
        look_nt("R9 horizontal A10=1", 3'b001, 1'b0);
        look_nt("R9 horizontal A11=1", 3'b010, 1'b1);
        cpu_wr(1'b1, 16'hA000, 8'hFE);
        chk("R9 upper bits dropped", {6'd0, mirror_mode}, 8'h02);
        look_nt("R9 single page 0", 3'b011, 1'b0);
        cpu_wr(1'b1, 16'hA000, 8'h03);
        look_nt("R9 single page 1", 3'b000, 1'b1);

        // R11: lower CPU half returns zero
        for (int w = 0; w < 4; w++) look_prg("R11 low half", 1'b1, 3'(w), 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule